// File: doc/BRIEF.md
# MSI Capability Register Block

This block holds the registers of a PCI message signalled interrupt capability. Software reaches it through a port that selects one dword at a time, with a byte enable for each byte lane. The block keeps the message control word, the message address and the message data. When per-vector masking is built in, it also keeps a mask word and a pending word. Two elaboration parameters choose the layout: `ADDR64` adds an upper address dword, and `MASKED` adds the mask and pending dwords. The register offsets, the capability length and the writable bits of each dword follow from these two parameters.

On the device side, a one-cycle interrupt request becomes one memory-write message on a valid/ready port. The message carries the programmed address and data, and at most one message is outstanding at a time. If the vector is masked when a request arrives, the block records the request as pending. It sends the message as soon as the mask clears. The block also pulses a flag when software turns MSI on, another when software turns it off, and a third when the message address or data changes while MSI is on.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset, every writable field reads zero, `msgValid` is low and dword 0 reads only the read-only capability bits. Bit 23 of dword 0 (control bit 7) equals `ADDR64`, and bit 24 (control bit 8) equals `MASKED`.
- R2: In dword 0, only bits 16 (enable, control bit 0), 22:20 (multiple-message enable, control bits 6:4) and 26 (extended-data enable, control bit 10) take writes. All other bits of dword 0 keep their value.
- R3: Dword 1 holds the low message address. Bits 1:0 always read zero, and each byte lane is written only when its byte enable is set.
- R4: With `ADDR64`, dword 2 holds the upper address and dword 3 holds the data word, and a write to either address dword leaves the other unchanged. Without `ADDR64`, dword 2 holds the data word and the message address bits 63:32 are zero.
- R5: With `MASKED`, the dword after the data word is a fully writable mask word. The next dword is the pending word, which reads bit 0 as pending and cannot be written. Dwords beyond the last one in the layout read zero and ignore writes.
- R6: A write that changes the enable bit from 0 to 1 pulses `evtEnabled`, and a write that changes it from 1 to 0 pulses `evtDisabled`. Each pulse lasts one cycle and appears in the cycle after the write's clock edge. No other write produces either pulse.
- R7: `evtRoute` pulses for one cycle after a write edge if, with MSI enabled, the write changes an address dword or bits 15:0 of the data word.
- R8: A request while MSI is enabled, the vector is unmasked (mask bit 0 clear or no masking) and no message is outstanding raises `msgValid` in the next cycle. The message carries the programmed address and, as its data, data bits 15:0 zero-extended to 32 bits.
- R9: While `msgValid` is high and `msgReady` is low, the message address and data stay stable, and later register writes do not change them. A request that arrives while a message is outstanding is merged into it, so no second message follows.
- R10: A request while enabled and masked sends no message and sets pending bit 0. One cycle after the write edge that clears mask bit 0, the held message becomes valid and pending bit 0 clears.
- R11: A request while MSI is disabled produces no message and does not set the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddr | input | 3 | Dword index within the capability |
| cfgWrEn | input | 1 | Write strobe |
| cfgByteEn | input | 4 | Byte lane enables for a write |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data for `cfgAddr`, combinational |
| irqReq | input | 1 | One-cycle interrupt request from the device |
| msgValid | output | 1 | Message write request valid |
| msgReady | input | 1 | Message accepted by the fabric |
| msgAddr | output | 64 | Message address |
| msgData | output | 32 | Message data, zero-extended |
| evtEnabled | output | 1 | One-cycle pulse when MSI turns on |
| evtDisabled | output | 1 | One-cycle pulse when MSI turns off |
| evtRoute | output | 1 | One-cycle pulse when the address or data changes while MSI is on |

## Verification
- **Read data:** it is combinational, so the bench samples it a fraction of a nanosecond after changing `cfgAddr`, inside a single clock phase.
- **Event pulses:** the three pulses and a new message are registered once, so each becomes visible in the cycle that follows the clock edge where its write or request was sampled. The bench drives every stimulus on a falling edge and samples at the next falling edge, which is exactly one rising edge later.
- **Mask release:** releasing a pending message costs one more cycle after the mask is written. The bench therefore checks that the message is still absent right after the mask write, and present one falling edge later.
- **Full register sweep:** a shadow copy of every dword for two configurations (64-bit with masking, and 32-bit without) predicts each read-back and event after the sweep of all dword indices against all sixteen byte-enable patterns.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic loadMsg;   // capture address and data into the message registers
    logic setPend;   // record a masked request
    logic clrPend;   // pending request has been turned into a message
  } msiStrobe_t;

  // Dword index of the data word for a given address width.
  function automatic int dataIndex(bit addr64);
    return addr64 ? 3 : 2;
  endfunction

  // Number of dwords present in the layout.
  function automatic int dwordCount(bit addr64, bit masked);
    return dataIndex(addr64) + (masked ? 3 : 1);
  endfunction

endpackage

// File: rtl/msi_cap_datapath.sv
module msi_cap_datapath
  import msi_cap_pkg::*;
#(
  parameter bit ADDR64 = 1'b1,
  parameter bit MASKED = 1'b1,
  parameter int IDX_W  = 3,
  parameter int DW     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] cfgAddr,
  input  logic             cfgWrEn,
  input  logic [DW/8-1:0]  cfgByteEn,
  input  logic [DW-1:0]    cfgWrData,
  output logic [DW-1:0]    cfgRdData,
  input  msiStrobe_t       strobe,
  output logic             msiEnable,
  output logic             maskBit,
  output logic             pendBit,
  output logic             enRise,
  output logic             enFall,
  output logic             routeChg,
  output logic [2*DW-1:0]  msgAddr,
  output logic [DW-1:0]    msgData
);

  localparam int DATA_IDX = dataIndex(ADDR64);
  localparam int MASK_IDX = DATA_IDX + 1;
  localparam int PEND_IDX = DATA_IDX + 2;
  localparam int NUM_DW   = dwordCount(ADDR64, MASKED);

  localparam logic [IDX_W-1:0] SEL_CTRL = IDX_W'(0);
  localparam logic [IDX_W-1:0] SEL_ALO  = IDX_W'(1);
  localparam logic [IDX_W-1:0] SEL_AHI  = IDX_W'(2);
  localparam logic [IDX_W-1:0] SEL_DATA = IDX_W'(DATA_IDX);
  localparam logic [IDX_W-1:0] SEL_MASK = IDX_W'(MASK_IDX);
  localparam logic [IDX_W-1:0] SEL_PEND = IDX_W'(PEND_IDX);

  localparam logic [DW-1:0] CTRL_WMASK = DW'(32'h0471_0000);
  localparam logic [DW-1:0] ALO_WMASK  = {{(DW-2){1'b1}}, 2'b00};
  localparam logic [DW-1:0] FULL_WMASK = {DW{1'b1}};

  logic          enableR;
  logic [2:0]    mmeR;
  logic          extEnR;
  logic [DW-1:0] addrLoR, addrHiR, dataR, maskR;
  logic          pendR;
  logic [2*DW-1:0] msgAddrR;
  logic [DW-1:0]   msgDataR;

  logic [15:0]   ctrlWord;
  logic [DW-1:0] readWord, wrMask, byteMask, enMask, newWord;
  logic          selCtrl, selAlo, selAhi, selData, selMask;

  assign ctrlWord = {5'b0, extEnR, 1'b0, MASKED, ADDR64, mmeR, 3'b000, enableR};

  // Read-back value of the addressed dword.
  always_comb begin
    readWord = '0;
    if (cfgAddr == SEL_CTRL)                 readWord = {ctrlWord, 16'h0000};
    else if (cfgAddr == SEL_ALO)             readWord = addrLoR;
    else if (ADDR64 && cfgAddr == SEL_AHI)   readWord = addrHiR;
    else if (cfgAddr == SEL_DATA)            readWord = dataR;
    else if (MASKED && cfgAddr == SEL_MASK)  readWord = maskR;
    else if (MASKED && cfgAddr == SEL_PEND)  readWord = {{(DW-1){1'b0}}, pendR};
  end
  assign cfgRdData = readWord;

  // Writable bits of the addressed dword.
  always_comb begin
    wrMask = '0;
    if (cfgAddr == SEL_CTRL)                 wrMask = CTRL_WMASK;
    else if (cfgAddr == SEL_ALO)             wrMask = ALO_WMASK;
    else if (ADDR64 && cfgAddr == SEL_AHI)   wrMask = FULL_WMASK;
    else if (cfgAddr == SEL_DATA)            wrMask = FULL_WMASK;
    else if (MASKED && cfgAddr == SEL_MASK)  wrMask = FULL_WMASK;
  end

  for (genvar b = 0; b < DW/8; b++) begin : g_lane
    assign byteMask[8*b +: 8] = {8{cfgByteEn[b]}};
  end

  assign enMask  = wrMask & byteMask;
  assign newWord = (readWord & ~enMask) | (cfgWrData & enMask);

  assign selCtrl = cfgWrEn && cfgAddr == SEL_CTRL;
  assign selAlo  = cfgWrEn && cfgAddr == SEL_ALO;
  assign selAhi  = ADDR64 && cfgWrEn && cfgAddr == SEL_AHI;
  assign selData = cfgWrEn && cfgAddr == SEL_DATA;
  assign selMask = MASKED && cfgWrEn && cfgAddr == SEL_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableR <= 1'b0;
      mmeR    <= '0;
      extEnR  <= 1'b0;
      addrLoR <= '0;
      dataR   <= '0;
    end else begin
      if (selCtrl) begin
        enableR <= newWord[16];
        mmeR    <= newWord[22:20];
        extEnR  <= newWord[26];
      end
      if (selAlo)  addrLoR <= newWord;
      if (selData) dataR   <= newWord;
    end
  end

  if (ADDR64) begin : g_hi
    always_ff @(posedge clk) begin
      if (!rstN)       addrHiR <= '0;
      else if (selAhi) addrHiR <= newWord;
    end
  end else begin : g_nohi
    assign addrHiR = '0;
  end

  if (MASKED) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rstN)        maskR <= '0;
      else if (selMask) maskR <= newWord;
    end
  end else begin : g_nomask
    assign maskR = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                pendR <= 1'b0;
    else if (strobe.setPend)  pendR <= 1'b1;
    else if (strobe.clrPend)  pendR <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgAddrR <= '0;
      msgDataR <= '0;
    end else if (strobe.loadMsg) begin
      msgAddrR <= {addrHiR, addrLoR};
      msgDataR <= {{(DW-16){1'b0}}, dataR[15:0]};
    end
  end

  assign msiEnable = enableR;
  assign maskBit   = maskR[0];
  assign pendBit   = pendR;
  assign msgAddr   = msgAddrR;
  assign msgData   = msgDataR;

  assign enRise   = selCtrl && !enableR &&  newWord[16];
  assign enFall   = selCtrl &&  enableR && !newWord[16];
  assign routeChg = enableR && ((selAlo  && newWord != addrLoR) ||
                                (selAhi  && newWord != addrHiR) ||
                                (selData && newWord[15:0] != dataR[15:0]));

  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgAddrR != '0) |-> msgAddrR[1:0] == 2'b00);

  if (!ADDR64) begin : g_chk32
    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.loadMsg |=> msgAddr[2*DW-1:DW] == '0);
  end

endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqReq,
  input  logic       msgReady,
  input  logic       msiEnable,
  input  logic       maskBit,
  input  logic       pendBit,
  input  logic       enRise,
  input  logic       enFall,
  input  logic       routeChg,
  output msiStrobe_t strobe,
  output logic       msgValid,
  output logic       evtEnabled,
  output logic       evtDisabled,
  output logic       evtRoute
);

  logic validR;
  logic deliverOk;
  logic idle;

  assign deliverOk = msiEnable && !maskBit;
  assign idle      = !validR;

  always_comb begin
    strobe         = '0;
    strobe.loadMsg = idle && deliverOk && (irqReq || pendBit);
    strobe.clrPend = strobe.loadMsg && pendBit;
    strobe.setPend = irqReq && msiEnable && maskBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   validR <= 1'b0;
    else if (strobe.loadMsg)     validR <= 1'b1;
    else if (validR && msgReady) validR <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtEnabled  <= 1'b0;
      evtDisabled <= 1'b0;
      evtRoute    <= 1'b0;
    end else begin
      evtEnabled  <= enRise;
      evtDisabled <= enFall;
      evtRoute    <= routeChg;
    end
  end

  assign msgValid = validR;

  // R6
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(evtEnabled && evtDisabled));

  // R9
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    validR && !msgReady |=> validR && !strobe.loadMsg);

  // R8
  msg_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validR) |-> $past(msiEnable && !maskBit));

  // R10
  pend_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendBit) |-> $past(maskBit && msiEnable && irqReq));

endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter bit ADDR64 = 1'b1,
  parameter bit MASKED = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  cfgAddr,
  input  logic        cfgWrEn,
  input  logic [3:0]  cfgByteEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic        irqReq,
  output logic        msgValid,
  input  logic        msgReady,
  output logic [63:0] msgAddr,
  output logic [31:0] msgData,
  output logic        evtEnabled,
  output logic        evtDisabled,
  output logic        evtRoute
);

  msiStrobe_t strobe;
  logic msiEnable, maskBit, pendBit, enRise, enFall, routeChg;

  msi_cap_datapath #(.ADDR64(ADDR64), .MASKED(MASKED), .IDX_W(3), .DW(32)) datapath (
    .clk(clk), .rstN(rstN),
    .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn), .cfgByteEn(cfgByteEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .strobe(strobe),
    .msiEnable(msiEnable), .maskBit(maskBit), .pendBit(pendBit),
    .enRise(enRise), .enFall(enFall), .routeChg(routeChg),
    .msgAddr(msgAddr), .msgData(msgData)
  );

  msi_cap_ctrl control (
    .clk(clk), .rstN(rstN),
    .irqReq(irqReq), .msgReady(msgReady),
    .msiEnable(msiEnable), .maskBit(maskBit), .pendBit(pendBit),
    .enRise(enRise), .enFall(enFall), .routeChg(routeChg),
    .strobe(strobe), .msgValid(msgValid),
    .evtEnabled(evtEnabled), .evtDisabled(evtDisabled), .evtRoute(evtRoute)
  );

endmodule

// File: tb/msi_cap_regs_test.sv
`timescale 1ns/100ps
module msi_cap_regs_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic        irqReq = 1'b0;
  logic        msgReady = 1'b0;

  logic [31:0] rd [2];
  logic        mv [2];
  logic [63:0] ma [2];
  logic [31:0] md [2];
  logic        eEn [2], eDis [2], eRt [2];

  // Instance 0: 64-bit with masking. Instance 1: 32-bit without masking.
  msi_cap_regs #(.ADDR64(1'b1), .MASKED(1'b1)) uut (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(rd[0]),
    .irqReq(irqReq), .msgValid(mv[0]), .msgReady(msgReady),
    .msgAddr(ma[0]), .msgData(md[0]),
    .evtEnabled(eEn[0]), .evtDisabled(eDis[0]), .evtRoute(eRt[0]));

  msi_cap_regs #(.ADDR64(1'b0), .MASKED(1'b0)) uut32 (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(rd[1]),
    .irqReq(irqReq), .msgValid(mv[1]), .msgReady(msgReady),
    .msgAddr(ma[1]), .msgData(md[1]),
    .evtEnabled(eEn[1]), .evtDisabled(eDis[1]), .evtRoute(eRt[1]));

  int errs = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] sh [2][8];

  task automatic chk(string req, int inst, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s inst%0d actual=%h expected=%h at %0t", req, inst, act, exp, $time);
    end
  endtask

  function automatic bit is64(int i);  return i == 0; endfunction
  function automatic bit hasMsk(int i); return i == 0; endfunction
  function automatic int dIdx(int i);  return is64(i) ? 3 : 2; endfunction

  // Writable bits per dword, from R2..R5.
  function automatic logic [31:0] wmask(int i, int idx);
    if (idx == 0) return 32'h0471_0000;
    if (idx == 1) return 32'hFFFF_FFFC;
    if (idx == 2) return 32'hFFFF_FFFF;
    if (idx == 3) return (is64(i) || hasMsk(i)) ? 32'hFFFF_FFFF : 32'h0;
    if (idx == 4) return (is64(i) && hasMsk(i)) ? 32'hFFFF_FFFF : 32'h0;
    return 32'h0;
  endfunction

  task automatic readAll(string req);
    for (int idx = 0; idx < 8; idx++) begin
      cfgAddr = 3'(idx);
      #0.1;
      for (int i = 0; i < 2; i++) chk(req, i, {32'h0, rd[i]}, {32'h0, sh[i][idx]});
    end
  endtask

  task automatic cfgWrite(int idx, logic [31:0] data, logic [3:0] be, string req);
    logic [31:0] nv [2];
    logic xr [2], xf [2], xrt [2];
    for (int i = 0; i < 2; i++) begin
      logic [31:0] bm, m, old;
      bm  = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
      m   = bm & wmask(i, idx);
      old = sh[i][idx];
      nv[i] = (old & ~m) | (data & m);
      xr[i] = idx == 0 && !old[16] &&  nv[i][16];
      xf[i] = idx == 0 &&  old[16] && !nv[i][16];
      xrt[i] = sh[i][0][16] &&
               ((idx == 1 && nv[i] != old) ||
                (is64(i) && idx == 2 && nv[i] != old) ||
                (idx == dIdx(i) && nv[i][15:0] != old[15:0]));
    end
    @(negedge clk);
    cfgAddr = 3'(idx); cfgWrData = data; cfgByteEn = be; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    for (int i = 0; i < 2; i++) begin
      chk("R6 enabled", i, {63'h0, eEn[i]}, {63'h0, xr[i]});
      chk("R6 disabled", i, {63'h0, eDis[i]}, {63'h0, xf[i]});
      chk("R7 route", i, {63'h0, eRt[i]}, {63'h0, xrt[i]});
      sh[i][idx] = nv[i];
    end
    readAll(req);
  endtask

  task automatic pulseIrq();
    @(negedge clk);
    irqReq = 1'b1;
    @(negedge clk);
    irqReq = 1'b0;
  endtask

  task automatic chkMsg(string req, int i, bit v, logic [63:0] a, logic [31:0] d);
    chk(req, i, {63'h0, mv[i]}, {63'h0, v});
    if (v) begin
      chk(req, i, ma[i], a);
      chk(req, i, {32'h0, md[i]}, {32'h0, d});
    end
  endtask

  initial begin
    for (int i = 0; i < 2; i++)
      for (int k = 0; k < 8; k++) sh[i][k] = '0;
    sh[0][0] = 32'h0180_0000;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readAll("R1");
    for (int i = 0; i < 2; i++) chk("R1 msgValid", i, {63'h0, mv[i]}, 64'h0);

    // Sweep of every dword against every byte-enable pattern (R2 R3 R4 R5).
    for (int p = 0; p < 2; p++)
      for (int idx = 0; idx < 8; idx++)
        for (int be = 0; be < 16; be++)
          cfgWrite(idx, (p == 0) ? 32'hFFFF_FFFF : 32'h5AC3_96E1 ^ (32'(be) << 9),
                   4'(be), idx == 0 ? "R2" : idx == 1 ? "R3" : idx < 4 ? "R4" : "R5");
    for (int idx = 1; idx < 8; idx++) cfgWrite(idx, 32'h0, 4'hF, "R5 clear");

    // Program address and data while disabled.
    cfgWrite(0, 32'h0, 4'hF, "R6");
    cfgWrite(1, 32'hDEAD_BEEF, 4'hF, "R3");
    cfgWrite(2, 32'h1234_5678, 4'hF, "R4");
    cfgWrite(3, 32'h0000_ABCD, 4'hF, "R4");
    cfgWrite(4, 32'h0, 4'hF, "R5");
    cfgWrite(0, 32'h0001_0000, 4'b0100, "R6");
    cfgWrite(0, 32'h0001_0000, 4'b0100, "R6 repeat");

    // R8 message content
    pulseIrq();
    chkMsg("R8", 0, 1, 64'h1234_5678_DEAD_BEEC, 32'h0000_ABCD);
    chkMsg("R8", 1, 1, 64'h0000_0000_DEAD_BEEC, 32'h0000_5678);
    // R9 held through a route-changing write and a merged request
    cfgWrite(1, 32'h0000_1000, 4'hF, "R7");
    cfgWrite(1, 32'h0000_1000, 4'hF, "R7 same");
    pulseIrq();
    @(negedge clk);
    chkMsg("R9 hold", 0, 1, 64'h1234_5678_DEAD_BEEC, 32'h0000_ABCD);
    chkMsg("R9 hold", 1, 1, 64'h0000_0000_DEAD_BEEC, 32'h0000_5678);
    msgReady = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2; i++) chkMsg("R9 accept", i, 0, 0, 0);
    @(negedge clk);
    for (int i = 0; i < 2; i++) chkMsg("R9 merged", i, 0, 0, 0);
    msgReady = 1'b0;

    // R10 masked request held as pending
    cfgWrite(4, 32'h0000_0001, 4'hF, "R5");
    pulseIrq();
    chkMsg("R10 masked", 0, 0, 0, 0);
    chkMsg("R8 unmasked", 1, 1, 64'h0000_0000_0000_1000, 32'h0000_5678);
    sh[0][5] = 32'h1;
    readAll("R10 pending");
    msgReady = 1'b1;
    @(negedge clk);
    msgReady = 1'b0;
    chkMsg("R9 accept", 1, 0, 0, 0);
    cfgWrite(4, 32'h0, 4'hF, "R10");
    chkMsg("R10 not yet", 0, 0, 0, 0);
    @(negedge clk);
    chkMsg("R10 release", 0, 1, 64'h1234_5678_0000_1000, 32'h0000_ABCD);
    sh[0][5] = 32'h0;
    readAll("R10 cleared");
    msgReady = 1'b1;
    @(negedge clk);
    msgReady = 1'b0;
    chkMsg("R10 drained", 0, 0, 0, 0);

    // R11 requests while disabled
    cfgWrite(0, 32'h0, 4'b0100, "R6");
    pulseIrq();
    for (int i = 0; i < 2; i++) chkMsg("R11", i, 0, 0, 0);
    @(negedge clk);
    for (int i = 0; i < 2; i++) chkMsg("R11", i, 0, 0, 0);
    cfgWrite(4, 32'h1, 4'hF, "R5");
    pulseIrq();
    readAll("R11 no pending");
    for (int i = 0; i < 2; i++) chkMsg("R11", i, 0, 0, 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule